// File: doc/BRIEF.md
# Exclusive Access Monitor (single core)

This block sits between one processor's load/store port and a small synchronous word memory. It lets software run a lock-free read-modify-write. A load-exclusive reads a location and arms a reservation that records the address and the access size. A later store-exclusive commits its data only while that reservation is still armed and still matches. The block reports the outcome as a one-bit status: 0 means the write took effect and 1 means it was dropped. Software retries on a 1.

The reservation is dropped by every store-exclusive, whatever its outcome. An explicit clear request also drops it, and so does an exception-entry pulse. As a result, a thread that is interrupted between its two halves cannot complete a stale update. Plain loads and stores pass through to the memory and do not touch the reservation. Every request receives exactly one response one cycle later, with read data for loads and the status for store-exclusives.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive (op code 2) returns the addressed data and leaves the reservation armed with that address and size.
- R2: A store-exclusive (op code 3) whose reservation is armed and matching responds with status 0 and writes memory. Otherwise it responds with status 1 and memory is unchanged.
- R3: Every store-exclusive disarms the reservation, whether it succeeded or failed.
- R4: A clear request (op code 4) disarms the reservation, does not access memory, and responds with status 0 and read data 0.
- R5: An exception-entry pulse disarms the reservation, so the next store-exclusive fails.
- R6: A match needs the same size code (0 byte, 1 halfword, 2 word) and the same address. Address bits below the access size are ignored: bit 0 for a halfword, and bits 1:0 for a word.
- R7: A load-exclusive issued while the reservation is armed replaces the recorded address and size, and the reservation stays armed.
- R8: Plain loads (op code 0) and plain stores (op code 1) leave the reservation unchanged.
- R9: If an exception-entry pulse arrives in the same cycle as a load-exclusive, the reservation ends up disarmed.
- R10: A store-exclusive that arrives in the same cycle as an exception-entry pulse fails.
- R11: After reset the reservation is disarmed and no response is pending. Each request yields rsp_valid exactly one cycle later, and no response appears without a request.
- R12: Byte and halfword stores modify only their byte lanes. Lane n holds bits 8n+7:8n and is selected by the low address bits, little-endian. Loads return the addressed lanes zero-extended, and stores respond with read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | 0 load, 1 store, 2 load-exclusive, 3 store-exclusive, 4 clear |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Store data, right-aligned |
| exc_entry | input | 1 | Exception-entry pulse |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Load data, zero-extended |
| rsp_status | output | 1 | Store-exclusive result: 0 success, 1 failure |

## Verification
The reservation cannot be seen directly. Its state shows up only as the status of the next store-exclusive and as the memory contents that a later plain load reads back. A reservation left armed when it should be cleared shows up as a wrong 0 status one cycle after that store-exclusive, and the following load then returns the illegally written value. A stale recorded address or size is exposed by pairs whose addresses or sizes differ slightly. A lane error appears in the word read back on the cycle after the load.

// File: rtl/excl_pkg.sv
package excl_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LDEX  = 3'd2,
    OP_STEX  = 3'd3,
    OP_CLREX = 3'd4
  } excl_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } excl_size_e;

  // Byte offset with the bits below the access size forced to zero.
  function automatic logic [1:0] norm_offset(excl_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: norm_offset = off;
      SZ_HALF: norm_offset = {off[1], 1'b0};
      default: norm_offset = 2'b00;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_enables(excl_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: lane_enables = 4'b0001 << off;
      SZ_HALF: lane_enables = off[1] ? 4'b1100 : 4'b0011;
      default: lane_enables = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/excl_tag_unit.sv
module excl_tag_unit
  import excl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  excl_op_e          req_op,
  input  logic [ADDR_W-1:0] norm_addr,
  input  excl_size_e        req_size,
  input  logic              exc_entry,
  output logic              stex_pass
);
  logic              tag_q, tag_d;
  logic [ADDR_W-1:0] taddr_q, taddr_d;
  excl_size_e        tsize_q, tsize_d;
  logic              is_ldex, is_stex, is_clrex, is_plain;

  assign is_ldex  = req_valid && (req_op == OP_LDEX);
  assign is_stex  = req_valid && (req_op == OP_STEX);
  assign is_clrex = req_valid && (req_op == OP_CLREX);
  assign is_plain = req_valid && ((req_op == OP_LOAD) || (req_op == OP_STORE));

  // Exception in the same cycle vetoes the store-exclusive.
  assign stex_pass = is_stex && tag_q && !exc_entry &&
                     (norm_addr == taddr_q) && (req_size == tsize_q);

  always_comb begin
    tag_d   = tag_q;
    taddr_d = taddr_q;
    tsize_d = tsize_q;
    if (exc_entry || is_stex || is_clrex) begin
      tag_d = 1'b0;
    end else if (is_ldex) begin
      tag_d   = 1'b1;
      taddr_d = norm_addr;
      tsize_d = req_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= 1'b0;
      taddr_q <= '0;
      tsize_q <= SZ_BYTE;
    end else begin
      tag_q   <= tag_d;
      taddr_q <= taddr_d;
      tsize_q <= tsize_d;
    end
  end

  AST_LDEX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ldex && !exc_entry) |=> tag_q); // R1
  AST_STEX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    is_stex |=> !tag_q); // R3
  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    is_clrex |=> !tag_q); // R4
  AST_EXC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !tag_q); // R5
  AST_PLAIN_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (is_plain && !exc_entry) |=> ($stable(tag_q) && $stable(taddr_q))); // R8
endmodule

// File: rtl/excl_lane_mem.sv
module excl_lane_mem
  import excl_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  excl_size_e        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  localparam int IDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] wdata_rep;
  logic [LANES-1:0]  lane_en;
  logic [IDX_W-1:0]  idx;

  assign idx     = addr[ADDR_W-1:2];
  assign lane_en = lane_enables(size, addr[1:0]);

  // Right-aligned store data replicated onto every lane it may land in.
  for (genvar g = 0; g < LANES; g++) begin : g_rep
    always_comb begin
      case (size)
        SZ_BYTE: wdata_rep[8*g +: 8] = wdata[7:0];
        SZ_HALF: wdata_rep[8*g +: 8] = wdata[8*(g%2) +: 8];
        default: wdata_rep[8*g +: 8] = wdata[8*g +: 8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l]) mem_q[idx][8*l +: 8] <= wdata_rep[8*l +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (re) rd_word <= mem_q[idx];
  end
endmodule

// File: rtl/excl_resp.sv
module excl_resp
  import excl_pkg::*;
#(
  parameter int UNUSED_PAD = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              is_read,
  input  logic              stex_fail,
  input  excl_size_e        size,
  input  logic [1:0]        offset,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rsp_valid,
  output logic              rsp_status,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic       valid_q, valid_d;
  logic       status_q, status_d;
  logic       read_q, read_d;
  excl_size_e size_q, size_d;
  logic [1:0] off_q, off_d;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    valid_d  = req_valid;
    status_d = req_valid && stex_fail;
    read_d   = req_valid && is_read;
    size_d   = size_q;
    off_d    = off_q;
    if (req_valid && is_read) begin
      size_d = size;
      off_d  = offset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      status_q <= 1'b0;
      read_q   <= 1'b0;
      size_q   <= SZ_WORD;
      off_q    <= 2'b00;
    end else begin
      valid_q  <= valid_d;
      status_q <= status_d;
      read_q   <= read_d;
      size_q   <= size_d;
      off_q    <= off_d;
    end
  end

  assign shifted = rd_word >> (8 * off_q);

  always_comb begin
    rsp_rdata = '0;
    if (read_q) begin
      case (size_q)
        SZ_BYTE: rsp_rdata = {24'd0, shifted[7:0]};
        SZ_HALF: rsp_rdata = {16'd0, shifted[15:0]};
        default: rsp_rdata = shifted;
      endcase
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_status = status_q;

  AST_STATUS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status |-> rsp_valid); // R11
  AST_FAIL_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && stex_fail) |=> rsp_status); // R2
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int ADDR_W    = $clog2(MEM_WORDS) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              exc_entry,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_status
);
  excl_op_e          op;
  excl_size_e        sz;
  logic [ADDR_W-1:0] addr_n;
  logic              stex_pass, stex_fail, is_read, mem_we, mem_re;
  logic [DATA_W-1:0] rd_word;

  assign op     = excl_op_e'(req_op);
  assign sz     = excl_size_e'(req_size);
  assign addr_n = {req_addr[ADDR_W-1:2], norm_offset(sz, req_addr[1:0])};

  assign is_read   = (op == OP_LOAD) || (op == OP_LDEX);
  assign stex_fail = (op == OP_STEX) && !stex_pass;
  assign mem_we    = req_valid && ((op == OP_STORE) || stex_pass);
  assign mem_re    = req_valid && is_read;

  excl_tag_unit #(.ADDR_W(ADDR_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (op),
    .norm_addr (addr_n),
    .req_size  (sz),
    .exc_entry (exc_entry),
    .stex_pass (stex_pass)
  );

  excl_lane_mem #(.WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .re      (mem_re),
    .addr    (addr_n),
    .size    (sz),
    .wdata   (req_wdata),
    .rd_word (rd_word)
  );

  excl_resp #(.UNUSED_PAD(0)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .is_read    (is_read),
    .stex_fail  (stex_fail),
    .size       (sz),
    .offset     (addr_n[1:0]),
    .rd_word    (rd_word),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata)
  );

  AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && stex_fail) |-> !mem_we); // R2
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R11
  AST_EXC_STEX_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_STEX && exc_entry) |=> rsp_status); // R10
  AST_CLEAR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_CLREX) |-> (!mem_we && !mem_re)); // R4
endmodule

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        exc_entry = 1'b0;
  logic        rsp_valid, rsp_status;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  excl_monitor #(.MEM_WORDS(64)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .exc_entry(exc_entry), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_status(rsp_status)
  );

  typedef struct {
    int          due;
    logic [31:0] rdata;
    logic        status;
    string       rq;
  } item_t;

  item_t       sq[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] mm [64];
  logic        m_tag = 1'b0;
  logic [7:0]  m_addr = 8'd0;
  logic [1:0]  m_size = 2'd0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] norm(input logic [7:0] a, input logic [1:0] s);
    return (s == 2'd0) ? a : (s == 2'd1) ? {a[7:1], 1'b0} : {a[7:2], 2'b00};
  endfunction

  // Driver with reference model: ops 0 load,1 store,2 ldex,3 stex,4 clear.
  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [1:0] s,
                       input logic [31:0] wd, input logic exc, input string rq);
    item_t       it;
    logic [7:0]  na;
    logic [31:0] w, sh;
    bit          pass;
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_size = s;
    req_wdata = wd; exc_entry = exc;
    na   = norm(a, s);
    w    = mm[na[7:2]];
    sh   = w >> (8 * na[1:0]);
    pass = (op == 3'd3) && m_tag && !exc && (na == m_addr) && (s == m_size);
    it.due    = cyc + 1;
    it.rq     = rq;
    it.status = (op == 3'd3) && !pass;
    it.rdata  = 32'd0;
    if (op == 3'd0 || op == 3'd2)
      it.rdata = (s == 2'd0) ? {24'd0, sh[7:0]} : (s == 2'd1) ? {16'd0, sh[15:0]} : sh;
    if (op == 3'd1 || pass) begin
      for (int l = 0; l < 4; l++) begin
        bit en;
        en = (s == 2'd0) ? (l == na[1:0]) : (s == 2'd1) ? ((l / 2) == na[1]) : 1'b1;
        if (en)
          w[8*l +: 8] = (s == 2'd0) ? wd[7:0] : (s == 2'd1) ? wd[8*(l%2) +: 8] : wd[8*l +: 8];
      end
      mm[na[7:2]] = w;
    end
    if (exc || op == 3'd3 || op == 3'd4) m_tag = 1'b0;
    else if (op == 3'd2) begin m_tag = 1'b1; m_addr = na; m_size = s; end
    sq.push_back(it);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0; exc_entry = 1'b0;
  endtask

  task automatic pulse_exc();
    @(posedge clk); #1;
    req_valid = 1'b0; exc_entry = 1'b1;
    m_tag = 1'b0;
  endtask

  // Monitor: pops the expected item due this cycle.
  always @(negedge clk) begin
    if (rst_n && !done && cyc > 2) begin
      if (sq.size() > 0 && sq[0].due == cyc) begin
        item_t it;
        it = sq.pop_front();
        check(rsp_valid == 1'b1, {it.rq, " R11 valid"}, {31'd0, rsp_valid}, 32'd1);
        check(rsp_status == it.status, {it.rq, " status"}, {31'd0, rsp_status}, {31'd0, it.status});
        check(rsp_rdata == it.rdata, {it.rq, " rdata"}, rsp_rdata, it.rdata);
      end else begin
        check(rsp_valid == 1'b0, "R11 no spurious response", {31'd0, rsp_valid}, 32'd0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 reset valid", {31'd0, rsp_valid}, 32'd0);
    check(rsp_status == 1'b0, "R11 reset status", {31'd0, rsp_status}, 32'd0);

    for (int i = 0; i < 5; i++)
      issue(3'd1, 8'(4 * i), 2'd2, 32'h1111_0000 + 32'(i * 32'h0101), 1'b0, "init store");
    // R11 / R2: store-exclusive straight after reset fails
    issue(3'd3, 8'h00, 2'd2, 32'hDEAD_BEEF, 1'b0, "R2 stex after reset");
    issue(3'd0, 8'h00, 2'd2, 0, 1'b0, "R2 unchanged");
    // R1 / R2 success path
    issue(3'd2, 8'h04, 2'd2, 0, 1'b0, "R1 ldex");
    issue(3'd3, 8'h04, 2'd2, 32'hCAFE_0004, 1'b0, "R2 stex pass");
    issue(3'd0, 8'h04, 2'd2, 0, 1'b0, "R2 written");
    // R3 second store-exclusive fails
    issue(3'd3, 8'h04, 2'd2, 32'hBAD0_0004, 1'b0, "R3 repeat stex");
    issue(3'd0, 8'h04, 2'd2, 0, 1'b0, "R3 unchanged");
    // R4 clear
    issue(3'd2, 8'h08, 2'd2, 0, 1'b0, "R4 ldex");
    issue(3'd4, 8'h08, 2'd2, 0, 1'b0, "R4 clear");
    issue(3'd3, 8'h08, 2'd2, 32'hBAD0_0008, 1'b0, "R4 stex after clear");
    // R5 exception pulse
    issue(3'd2, 8'h08, 2'd2, 0, 1'b0, "R5 ldex");
    pulse_exc();
    issue(3'd3, 8'h08, 2'd2, 32'hBAD1_0008, 1'b0, "R5 stex after exception");
    issue(3'd0, 8'h08, 2'd2, 0, 1'b0, "R5 unchanged");
    // R6 size and address matching
    issue(3'd2, 8'h0D, 2'd0, 0, 1'b0, "R6 ldex byte");
    issue(3'd3, 8'h0C, 2'd1, 32'h0000_AAAA, 1'b0, "R6 size mismatch");
    issue(3'd2, 8'h0D, 2'd0, 0, 1'b0, "R6 ldex byte");
    issue(3'd3, 8'h0E, 2'd0, 32'h0000_00BB, 1'b0, "R6 addr mismatch");
    issue(3'd2, 8'h0D, 2'd0, 0, 1'b0, "R6 ldex byte");
    issue(3'd3, 8'h0D, 2'd0, 32'h0000_00CC, 1'b0, "R6 byte pass");
    issue(3'd0, 8'h0C, 2'd2, 0, 1'b0, "R12 byte lane");
    issue(3'd2, 8'h03, 2'd2, 0, 1'b0, "R6 ldex word low bits");
    issue(3'd3, 8'h01, 2'd2, 32'h5555_0000, 1'b0, "R6 word ignores low bits");
    // R7 overwrite
    issue(3'd2, 8'h00, 2'd2, 0, 1'b0, "R7 ldex A");
    issue(3'd2, 8'h10, 2'd2, 0, 1'b0, "R7 ldex B");
    issue(3'd3, 8'h00, 2'd2, 32'hBAD2_0000, 1'b0, "R7 old addr fails");
    issue(3'd2, 8'h00, 2'd2, 0, 1'b0, "R7 ldex A");
    issue(3'd2, 8'h10, 2'd2, 0, 1'b0, "R7 ldex B");
    issue(3'd3, 8'h10, 2'd2, 32'hCAFE_0010, 1'b0, "R7 new addr passes");
    // R8 plain traffic keeps the reservation
    issue(3'd2, 8'h08, 2'd2, 0, 1'b0, "R8 ldex");
    issue(3'd0, 8'h00, 2'd2, 0, 1'b0, "R8 plain load");
    issue(3'd1, 8'h04, 2'd2, 32'h7777_0004, 1'b0, "R8 plain store");
    issue(3'd3, 8'h08, 2'd2, 32'hCAFE_0008, 1'b0, "R8 stex pass");
    // R9 exception with load-exclusive
    issue(3'd2, 8'h08, 2'd2, 0, 1'b1, "R9 ldex with exception");
    issue(3'd3, 8'h08, 2'd2, 32'hBAD3_0008, 1'b0, "R9 stex fails");
    // R10 exception with store-exclusive
    issue(3'd2, 8'h08, 2'd2, 0, 1'b0, "R10 ldex");
    issue(3'd3, 8'h08, 2'd2, 32'hBAD4_0008, 1'b1, "R10 stex with exception");
    issue(3'd0, 8'h08, 2'd2, 0, 1'b0, "R10 unchanged");
    // R12 halfword lanes
    issue(3'd1, 8'h12, 2'd1, 32'h0000_9A8B, 1'b0, "R12 half store");
    issue(3'd0, 8'h13, 2'd0, 0, 1'b0, "R12 byte load");
    issue(3'd2, 8'h12, 2'd1, 0, 1'b0, "R12 half ldex");
    issue(3'd3, 8'h13, 2'd1, 32'h0000_1234, 1'b0, "R12 half stex odd addr");
    issue(3'd0, 8'h10, 2'd2, 0, 1'b0, "R12 word readback");
    idle();
    repeat (4) @(posedge clk);
    check(sq.size() == 0, "R11 all responses seen", 32'(sq.size()), 32'd0);
    finish_run();
  end
endmodule